// File: doc/BRIEF.md
# Parallel-Port Adapter Unlock Detector

This block sits on the device side of a parallel-port-to-disk adapter. It watches the host's eight data lines and four control lines for a fixed unlock pattern. The pattern is a seven-byte magic prefix followed by a command byte. The host confirms the command with a strobe on the control lines. The block decodes an attach or a detach command and keeps an attached flag that the rest of the adapter uses to decide whether it answers the host. It also shows an identification value, one nibble at a time, on the upper four status lines at set points in the pattern. A host that reads all three nibbles sees 0xB5F.

Both host buses are asynchronous to the system clock. Each passes through a two-flop synchronizer. The matcher takes one step each time the synchronized data value changes, so a byte that repeats the previous value is not a new step. A byte that breaks the order sends the matcher back to idle. The first magic byte is an exception: it restarts the match at once.

Top module: `pport_unlock_detect`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears its state. stat_nib becomes 0x0, attached becomes 0, cmd_fire becomes 0 and cmd_kind becomes 0 (none).
- R2: The magic prefix is 0xFE, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78, in that order. Each step is one change of the synchronized data value. A byte equal to the byte before it causes no step.
- R3: stat_nib shows 0xB while the prefix is matched through 0xFF and the data is unchanged. It shows 0x5 once 0x87 has matched. It shows 0x0 everywhere else in the prefix.
- R4: The byte after the prefix is the command. The command takes effect only when the control lines then go from 0x4 to 0x5 and back to 0x4. A data change before the return to 0x4 abandons the command.
- R5: Command 0x20 sets attached and sets cmd_kind to 1. Command 0x30 clears attached and sets cmd_kind to 2. Any other command sets cmd_kind to 3 and leaves attached unchanged. Each command that takes effect raises cmd_fire for exactly one clock.
- R6: If the command byte is 0x20, stat_nib shows 0xF from the control value 0x5 until the sequence ends. For any other command it stays 0x0.
- R7: A byte that breaks the prefix order returns the matcher to idle. A 0xFE byte instead restarts the match with 0xAA as the next byte expected.
- R8: After a command takes effect, the host writes the end byte 0xFF. That byte returns the matcher to idle, and stat_nib then shows 0x0.
- R9: A control strobe outside the command-wait point has no effect. This covers a strobe while idle and a strobe before the command byte: cmd_fire stays low and attached is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data | input | 8 | Host data lines (asynchronous) |
| host_ctl | input | 4 | Host control lines (asynchronous) |
| stat_nib | output | 4 | Value driven onto status lines 7:4 |
| attached | output | 1 | Adapter attached to the host |
| cmd_fire | output | 1 | One-clock pulse when a command takes effect |
| cmd_kind | output | 2 | Last command: 0 none, 1 attach, 2 detach, 3 other |

## Verification
The assertions assume the host holds every data byte and every control value for at least three system clocks. They also assume the host never changes the data and the control lines close enough together for both changes to reach the matcher in the same cycle. Under those conditions each host write becomes exactly one matcher step, and the status nibble can only move through the legal values. The bench keeps within these limits by holding every write for six clocks and by driving data and control one at a time. Its sweep sends every possible command byte through the full pattern. That includes a command equal to the last magic byte, which by R2 is not seen as a new step.

// File: rtl/pport_unlock_pkg.sv
// Package: shared constants and types for the parallel-port unlock detector.
// Assumes the magic prefix, the command codes and the identifier nibbles are
// fixed by the host-side protocol.
package pport_unlock_pkg;

    localparam int DATA_W    = 8;
    localparam int CTL_W     = 4;
    localparam int NIB_W     = 4;
    localparam int MAGIC_LEN = 7;
    localparam int IDX_W     = $clog2(MAGIC_LEN + 1);

    localparam logic [DATA_W-1:0] CMD_ATTACH = 8'h20;
    localparam logic [DATA_W-1:0] CMD_DETACH = 8'h30;
    localparam logic [CTL_W-1:0]  CTL_REST   = 4'h4;
    localparam logic [CTL_W-1:0]  CTL_ACT    = 4'h5;

    localparam logic [NIB_W-1:0]  ID_NIB_HI  = 4'hB;
    localparam logic [NIB_W-1:0]  ID_NIB_MID = 4'h5;
    localparam logic [NIB_W-1:0]  ID_NIB_LO  = 4'hF;
    localparam logic [NIB_W-1:0]  NIB_BLANK  = 4'h0;

    // Number of matched prefix bytes at which each identifier nibble shows.
    localparam int POS_ID_HI  = 5;
    localparam int POS_ID_MID = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CMD,
        ST_STRB,
        ST_END
    } mstate_e;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_ATTACH = 2'd1,
        KIND_DETACH = 2'd2,
        KIND_OTHER  = 2'd3
    } kind_e;

    // Expected byte at a given prefix position (0-based).
    function automatic logic [DATA_W-1:0] magic_byte(input logic [IDX_W-1:0] pos);
        case (pos)
            3'd0:    magic_byte = 8'hFE;
            3'd1:    magic_byte = 8'hAA;
            3'd2:    magic_byte = 8'h55;
            3'd3:    magic_byte = 8'h00;
            3'd4:    magic_byte = 8'hFF;
            3'd5:    magic_byte = 8'h87;
            3'd6:    magic_byte = 8'h78;
            default: magic_byte = 8'hFE;
        endcase
    endfunction

endpackage

// File: rtl/pport_sync.sv
// Module: multi-stage synchronizer with a change detector.
// Assumes the input is asynchronous and is held long enough to settle;
// a change shows as a one-cycle 'changed' when the settled value differs
// from the value one cycle earlier.
module pport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev,
    output logic         changed
);

    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    // First stage: capture the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Further stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Hold the previous settled value for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) q_prev <= '0;
        else        q_prev <= chain[LAST];
    end

    assign q       = chain[LAST];
    assign changed = (chain[LAST] != q_prev);

endmodule

// File: rtl/pport_matcher.sv
// Module: unlock sequence matcher.
// Steps once per change of the settled data value. It walks the magic prefix,
// latches the command byte, waits for the control strobe rest->active->rest
// and then for the end byte. Assumes data and control changes arrive in
// separate cycles; if they coincide, the data change wins.
module pport_matcher
    import pport_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dat,
    input  logic              dat_chg,
    input  logic [CTL_W-1:0]  ctl,
    input  logic [CTL_W-1:0]  ctl_prev,
    output mstate_e           state,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              commit
);

    localparam logic [IDX_W-1:0] LEN = IDX_W'(MAGIC_LEN);

    mstate_e           state_n;
    logic [IDX_W-1:0]  idx_n;
    logic [DATA_W-1:0] cmd_n;
    logic              commit_n;
    logic              is_start;
    logic              ctl_rise;

    assign is_start = (dat == magic_byte('0));
    assign ctl_rise = (ctl == CTL_ACT) && (ctl_prev == CTL_REST);

    // Next-state decode for one matcher step.
    always_comb begin
        state_n  = state;
        idx_n    = idx;
        cmd_n    = cmd_byte;
        commit_n = 1'b0;
        case (state)
            ST_IDLE: begin
                if (dat_chg && is_start) begin
                    state_n = ST_PRE;
                    idx_n   = IDX_W'(1);
                end
            end
            ST_PRE: begin
                if (dat_chg) begin
                    if (idx == LEN) begin
                        cmd_n   = dat;
                        state_n = ST_CMD;
                    end else if (dat == magic_byte(idx)) begin
                        idx_n = idx + IDX_W'(1);
                    end else if (is_start) begin
                        idx_n = IDX_W'(1);
                    end else begin
                        state_n = ST_IDLE;
                        idx_n   = '0;
                    end
                end
            end
            ST_CMD: begin
                if (dat_chg) begin
                    state_n = is_start ? ST_PRE : ST_IDLE;
                    idx_n   = is_start ? IDX_W'(1) : '0;
                end else if (ctl_rise) begin
                    state_n = ST_STRB;
                end
            end
            ST_STRB: begin
                if (dat_chg) begin
                    state_n = is_start ? ST_PRE : ST_IDLE;
                    idx_n   = is_start ? IDX_W'(1) : '0;
                end else if (ctl == CTL_REST) begin
                    state_n  = ST_END;
                    commit_n = 1'b1;
                end else if (ctl != CTL_ACT) begin
                    state_n = ST_IDLE;
                    idx_n   = '0;
                end
            end
            ST_END: begin
                if (dat_chg) begin
                    state_n = is_start ? ST_PRE : ST_IDLE;
                    idx_n   = is_start ? IDX_W'(1) : '0;
                end
            end
            default: begin
                state_n = ST_IDLE;
                idx_n   = '0;
            end
        endcase
    end

    // State, position, command latch and commit pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            cmd_byte <= '0;
            commit   <= 1'b0;
        end else begin
            state    <= state_n;
            idx      <= idx_n;
            cmd_byte <= cmd_n;
            commit   <= commit_n;
        end
    end

endmodule

// File: rtl/pport_cmd_dec.sv
// Module: command decoder and attach flag.
// On each commit pulse it classifies the latched command byte, updates the
// attached flag and raises a one-cycle fire pulse.
module pport_cmd_dec
    import pport_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] cmd_byte,
    output logic              fire,
    output kind_e             kind,
    output logic              attached
);

    kind_e kind_n;

    // Classify the latched command byte.
    always_comb begin
        if (cmd_byte == CMD_ATTACH)      kind_n = KIND_ATTACH;
        else if (cmd_byte == CMD_DETACH) kind_n = KIND_DETACH;
        else                             kind_n = KIND_OTHER;
    end

    // Register the decoded result and the attach flag at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire     <= 1'b0;
            kind     <= KIND_NONE;
            attached <= 1'b0;
        end else begin
            fire <= commit;
            if (commit) begin
                kind <= kind_n;
                if (kind_n == KIND_ATTACH)      attached <= 1'b1;
                else if (kind_n == KIND_DETACH) attached <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pport_status.sv
// Module: identifier nibble driver.
// Chooses the value for status lines 7:4 from the matcher position and
// registers it, so the output is glitch-free.
module pport_status
    import pport_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mstate_e           state,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] cmd_byte,
    output logic [NIB_W-1:0]  nib
);

    logic [NIB_W-1:0] nib_n;
    logic             late_id;

    assign late_id = ((state == ST_STRB) || (state == ST_END)) && (cmd_byte == CMD_ATTACH);

    // Pick the nibble for the current matcher position.
    always_comb begin
        nib_n = NIB_BLANK;
        if (state == ST_PRE && idx == IDX_W'(POS_ID_HI))       nib_n = ID_NIB_HI;
        else if (state == ST_PRE && idx == IDX_W'(POS_ID_MID)) nib_n = ID_NIB_MID;
        else if (late_id)                                      nib_n = ID_NIB_LO;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) nib <= NIB_BLANK;
        else        nib <= nib_n;
    end

endmodule

// File: rtl/pport_unlock_detect.sv
// Module: top of the parallel-port unlock detector.
// Synchronizes the host data and control lines, runs the sequence matcher,
// decodes the command and drives the identifier nibble. Assumes the host
// holds every value for several system clocks.
module pport_unlock_detect
    import pport_unlock_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  host_data,
    input  logic [3:0]  host_ctl,
    output logic [3:0]  stat_nib,
    output logic        attached,
    output logic        cmd_fire,
    output logic [1:0]  cmd_kind
);

    logic [DATA_W-1:0] dat_q, dat_p;
    logic              dat_chg;
    logic [CTL_W-1:0]  ctl_q, ctl_p;
    logic              ctl_chg;
    mstate_e           mstate;
    logic [IDX_W-1:0]  midx;
    logic [DATA_W-1:0] mcmd;
    logic              mcommit;
    kind_e             kind;

    pport_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(host_data),
        .q(dat_q), .q_prev(dat_p), .changed(dat_chg)
    );

    pport_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d(host_ctl),
        .q(ctl_q), .q_prev(ctl_p), .changed(ctl_chg)
    );

    pport_matcher u_match (
        .clk(clk), .rst_n(rst_n),
        .dat(dat_q), .dat_chg(dat_chg),
        .ctl(ctl_q), .ctl_prev(ctl_p),
        .state(mstate), .idx(midx), .cmd_byte(mcmd), .commit(mcommit)
    );

    pport_cmd_dec u_dec (
        .clk(clk), .rst_n(rst_n),
        .commit(mcommit), .cmd_byte(mcmd),
        .fire(cmd_fire), .kind(kind), .attached(attached)
    );

    pport_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .state(mstate), .idx(midx), .cmd_byte(mcmd),
        .nib(stat_nib)
    );

    assign cmd_kind = kind;

endmodule

// File: rtl/pport_unlock_chk.sv
// Module: property checker for the unlock detector, bound to the top.
module pport_unlock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] stat_nib,
    input logic       attached,
    input logic       cmd_fire,
    input logic [1:0] cmd_kind,
    input logic       ctl_chg
);

    logic was_in_rst = 1'b0;

    // Remember whether reset was applied at the previous edge.
    always_ff @(posedge clk) was_in_rst <= !rst_n;

    // R1: one edge after reset, all outputs are in their cleared state.
    always_ff @(posedge clk) begin
        if (was_in_rst) begin
            p_reset_clears_r1: assert (stat_nib == 4'h0 && !attached && !cmd_fire && cmd_kind == 2'd0)
                else $error("reset state wrong");
        end
    end

    p_status_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_nib == 4'h0 || stat_nib == 4'hB || stat_nib == 4'h5 || stat_nib == 4'hF));

    p_mid_follows_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_nib == 4'h5 && $past(stat_nib) != 4'h5) |-> $past(stat_nib) == 4'hB);

    p_fire_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> !cmd_fire);

    p_attach_needs_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(attached) |-> cmd_fire);

    p_attach_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attached) |-> cmd_kind == 2'd1);

    p_lo_from_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_nib == 4'hF && $past(stat_nib) != 4'hF) |-> $past(stat_nib) == 4'h0);

endmodule

bind pport_unlock_detect pport_unlock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stat_nib(stat_nib), .attached(attached),
    .cmd_fire(cmd_fire), .cmd_kind(cmd_kind), .ctl_chg(ctl_chg)
);

// File: tb/pport_unlock_detect_bench.sv
module pport_unlock_detect_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic [3:0] host_ctl = 4'h4;
    logic [3:0] stat_nib;
    logic       attached;
    logic       cmd_fire;
    logic [1:0] cmd_kind;

    int checks = 0;
    int failures = 0;
    int fires = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pport_unlock_detect u_pport_unlock_detect (
        .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_ctl(host_ctl),
        .stat_nib(stat_nib), .attached(attached), .cmd_fire(cmd_fire), .cmd_kind(cmd_kind)
    );

    // Count fire pulses seen at the outputs.
    always @(posedge clk) if (rst_n && cmd_fire) fires <= fires + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk) host_data = b;
        repeat (6) @(negedge clk);
    endtask

    task automatic put_ctl(input logic [3:0] c);
        @(negedge clk) host_ctl = c;
        repeat (6) @(negedge clk);
    endtask

    task automatic prefix();
        put(8'hFE); put(8'hAA); put(8'h55); put(8'h00);
        put(8'hFF); put(8'h87); put(8'h78);
    endtask

    // Full pattern with strobe; returns the nibble seen during the strobe.
    task automatic run_cmd(input logic [7:0] cmd, output logic [3:0] nib_strobe);
        prefix();
        put(cmd);
        put_ctl(4'h5);
        nib_strobe = stat_nib;
        put_ctl(4'h4);
        put(8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] ns;
        int f0;
        bit att_m;
        int kind_m;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 stat", stat_nib, 0);
        chk("R1 attached", attached, 0);
        chk("R1 kind", cmd_kind, 0);
        chk("R1 fire", cmd_fire, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2/R3/R6/R5/R8 attach walk-through
        put(8'hFE); put(8'hAA); put(8'h55); put(8'h00);
        chk("R3 blank before FF", stat_nib, 0);
        put(8'hFF);
        chk("R3 hi nibble", stat_nib, 4'hB);
        put(8'h87);
        chk("R3 mid nibble", stat_nib, 4'h5);
        put(8'h78);
        chk("R3 blank after 78", stat_nib, 0);
        put(8'h20);
        chk("R6 blank before strobe", stat_nib, 0);
        f0 = fires;
        put_ctl(4'h5);
        chk("R6 lo nibble", stat_nib, 4'hF);
        chk("R4 no commit at active", fires - f0, 0);
        put_ctl(4'h4);
        chk("R6 lo held", stat_nib, 4'hF);
        chk("R5 attached", attached, 1);
        chk("R5 kind attach", cmd_kind, 1);
        chk("R5 single fire", fires - f0, 1);
        put(8'hFF);
        chk("R8 end blank", stat_nib, 0);

        // R9 strobe while idle
        f0 = fires;
        put_ctl(4'h5); put_ctl(4'h4);
        chk("R9 idle strobe", fires - f0, 0);
        // R9 strobe before command byte, then abandon
        prefix();
        put_ctl(4'h5); put_ctl(4'h4);
        put(8'h30);
        put(8'h11);
        chk("R9 early strobe", fires - f0, 0);
        chk("R9 attached kept", attached, 1);

        // R4 command abandoned by data change during strobe
        prefix(); put(8'h30); put_ctl(4'h5); put(8'h12); put_ctl(4'h4);
        chk("R4 abandoned", fires - f0, 0);
        chk("R4 attached kept", attached, 1);

        // R7 broken order then FE restart mid-prefix
        put(8'hFE); put(8'hAA); put(8'h12); put(8'h55); put(8'h00); put(8'hFF);
        chk("R7 broken no hi", stat_nib, 0);
        put(8'hFE); put(8'hAA); put(8'h55); put(8'hFE); put(8'hAA); put(8'h55);
        put(8'h00); put(8'hFF);
        chk("R7 restart hi", stat_nib, 4'hB);
        put(8'h87); put(8'h78); put(8'h30); put_ctl(4'h5);
        chk("R6 no lo for detach", stat_nib, 0);
        put_ctl(4'h4);
        chk("R5 detached", attached, 0);
        chk("R5 kind detach", cmd_kind, 2);
        put(8'hFF);

        // R5/R6/R2 sweep of every command byte
        att_m = 1'b0;
        kind_m = 2;
        for (int c = 0; c < 256; c++) begin
            f0 = fires;
            run_cmd(8'(c), ns);
            if (c != 8'h78) begin
                if (c == 8'h20) begin att_m = 1'b1; kind_m = 1; end
                else if (c == 8'h30) begin att_m = 1'b0; kind_m = 2; end
                else kind_m = 3;
            end
            chk("R5 sweep fires", fires - f0, (c == 8'h78) ? 0 : 1);
            chk("R5 sweep kind", cmd_kind, kind_m);
            chk("R5 sweep attached", attached, att_m);
            chk("R6 sweep nibble", ns, (c == 8'h20) ? 4'hF : 4'h0);
            if (c == 8'h78) put(8'h00);
        end

        // R1 reset in mid-sequence
        run_cmd(8'h20, ns);
        put(8'hFE); put(8'hAA); put(8'h55); put(8'h00); put(8'hFF);
        chk("R3 hi before reset", stat_nib, 4'hB);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 mid stat", stat_nib, 0);
        chk("R1 mid attached", attached, 0);
        chk("R1 mid kind", cmd_kind, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule